// File: doc/BRIEF.md
# Priority-Masked Bus Request Arbiter

This arbiter decides who takes the bus next: the processor, or one of the requesters that compete for it. There are three kinds of requester. A direct-transfer line moves data without raising an interrupt. Four hardware interrupt lines sit at fixed levels 4 to 7. The third is the level of a pending software interrupt. Several devices may share each hardware line. Among devices on the same line, the one with the lowest index is treated as electrically nearest and wins.

A direct-transfer request can take the bus in any cycle. An interrupt-capable request is considered only in a cycle where the instruction-boundary strobe is high. It must also sit at a level strictly above the 3-bit processor priority, which is taken from the status word. When an interrupt request and a software request share a level, the software request wins. The winner gets a registered one-hot grant and keeps it until it drops its request. No arbitration takes place while a grant is active. When no grant is active, the processor owns the bus.

Top module: `bus_req_arbiter`

## Requirements
- R1: While reset is low and in the first cycle after it, no grant is active and `cpu_owns_o` is 1.
- R2: If no grant is active and any bit of `npr_req_i` is set, the next clock edge grants a direct-transfer device. This happens regardless of `instr_end_i` and regardless of `cpu_pri_i`, including priority 7.
- R3: A hardware line or software request is granted only at a clock edge where `instr_end_i` is 1.
- R4: A hardware line at level L (bit group i of `br_req_i` has L = 4 + i) is never granted when L <= `cpu_pri_i`. A software request at level `pir_level_i` is never granted when that level <= `cpu_pri_i`. A `pir_level_i` of 0 means no software request.
- R5: Among eligible hardware lines, the line with the highest level is granted.
- R6: On a shared line, the set request bit with the lowest index is granted. Device d of line i uses bit i*4+d of `br_req_i`, and device d of the direct-transfer line uses bit d of `npr_req_i`.
- R7: A software request wins over a hardware line at the same level. A hardware line at a higher level wins over a software request.
- R8: A direct-transfer request wins over every hardware line and software request presented in the same cycle.
- R9: While the granted requester keeps its request, the grant stays unchanged. Changes on all other request inputs, on `cpu_pri_i` and on `instr_end_i` have no effect on it.
- R10: At the first clock edge where the granted request is low, the grant is cleared and `cpu_owns_o` returns to 1. For a software grant, "low" means `pir_level_i` is 0.
- R11: At most one grant bit is high at any time, and `cpu_owns_o` is 1 exactly when none is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_pri_i | input | 3 | Processor priority taken from the status word |
| instr_end_i | input | 1 | Instruction-boundary strobe |
| npr_req_i | input | 4 | Direct-transfer requests, one bit per device |
| br_req_i | input | 16 | Hardware interrupt requests, four devices per line, lines at levels 4 to 7 |
| pir_level_i | input | 3 | Pending software interrupt level, 0 means none |
| npr_gnt_o | output | 4 | Direct-transfer grant, one-hot |
| br_gnt_o | output | 16 | Hardware line grant, one-hot, same bit layout as the requests |
| pir_gnt_o | output | 1 | Software interrupt grant |
| cpu_owns_o | output | 1 | Processor keeps the bus |

## Verification
The main function is tried with several request patterns:
- Eligible hardware lines at different levels, which separates level ordering from positional ordering.
- Several devices on one line, which checks the nearest-device rule.
- Software and hardware requests at equal levels and at neighbouring levels, which separates tie precedence from level precedence.
- Requests at or below the processor priority, including priority 7 with a direct-transfer request, which shows the masking applies to interrupt-capable requests only.
- Requests held steady while the strobe is low, which shows that interrupt-capable grants wait for the boundary.
- Request and priority changes made during a held grant, followed by a withdrawal, which separate holding from release.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_NPR  = 2'd1,
    SRC_BR   = 2'd2,
    SRC_PIR  = 2'd3
  } src_e;
endpackage

// File: rtl/first_one.sv
module first_one #(
  parameter int W = 4
) (
  input  logic [W-1:0] req_i,
  output logic [W-1:0] oh_o,
  output logic         any_o
);
  // two's-complement isolate of the lowest set bit
  assign oh_o  = req_i & (~req_i + W'(1));
  assign any_o = |req_i;
endmodule

// File: rtl/level_pick.sv
module level_pick
  import arb_pkg::*;
#(
  parameter int NUM_BR  = 4,
  parameter int BR_BASE = 4,
  parameter int PRI_W   = 3,
  parameter int LINE_W  = 2
) (
  input  logic [NUM_BR-1:0] line_any_i,
  input  logic [PRI_W-1:0]  pir_level_i,
  input  logic [PRI_W-1:0]  cpu_pri_i,
  output src_e              win_src_o,
  output logic [LINE_W-1:0] win_line_o
);
  localparam int LEVELS = 1 << PRI_W;

  logic [LEVELS-1:0] lvl_br;

  always_comb begin
    lvl_br = '0;
    for (int i = 0; i < NUM_BR; i++) begin
      if (BR_BASE + i < LEVELS) lvl_br[BR_BASE+i] = line_any_i[i];
    end
  end

  // ascending scan: later (higher) levels override; software overrides at a tie
  always_comb begin
    win_src_o  = SRC_NONE;
    win_line_o = '0;
    for (int lvl = 1; lvl < LEVELS; lvl++) begin
      if (lvl > int'(cpu_pri_i)) begin
        if (lvl_br[lvl]) begin
          win_src_o  = SRC_BR;
          win_line_o = LINE_W'(lvl - BR_BASE);
        end
        if (int'(pir_level_i) == lvl) begin
          win_src_o  = SRC_PIR;
          win_line_o = '0;
        end
      end
    end
  end
endmodule

// File: rtl/grant_reg.sv
module grant_reg
  import arb_pkg::*;
#(
  parameter int DEVS   = 4,
  parameter int LINE_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              clear_i,
  input  src_e              src_d_i,
  input  logic [LINE_W-1:0] line_d_i,
  input  logic [DEVS-1:0]   dev_d_i,
  output src_e              src_q_o,
  output logic [LINE_W-1:0] line_q_o,
  output logic [DEVS-1:0]   dev_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q_o  <= SRC_NONE;
      line_q_o <= '0;
      dev_q_o  <= '0;
    end else if (clear_i) begin
      src_q_o  <= SRC_NONE;
      line_q_o <= '0;
      dev_q_o  <= '0;
    end else if (load_i) begin
      src_q_o  <= src_d_i;
      line_q_o <= line_d_i;
      dev_q_o  <= dev_d_i;
    end
  end
endmodule

// File: rtl/bus_req_arbiter.sv
module bus_req_arbiter
  import arb_pkg::*;
#(
  parameter int DEVS    = 4,
  parameter int NUM_BR  = 4,
  parameter int BR_BASE = 4,
  parameter int PRI_W   = 3
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [PRI_W-1:0]       cpu_pri_i,
  input  logic                   instr_end_i,
  input  logic [DEVS-1:0]        npr_req_i,
  input  logic [NUM_BR*DEVS-1:0] br_req_i,
  input  logic [PRI_W-1:0]       pir_level_i,
  output logic [DEVS-1:0]        npr_gnt_o,
  output logic [NUM_BR*DEVS-1:0] br_gnt_o,
  output logic                   pir_gnt_o,
  output logic                   cpu_owns_o
);
  localparam int LINE_W = (NUM_BR > 1) ? $clog2(NUM_BR) : 1;

  logic [NUM_BR-1:0][DEVS-1:0] line_req;
  logic [NUM_BR-1:0][DEVS-1:0] line_oh;
  logic [NUM_BR-1:0]           line_any;
  logic [DEVS-1:0]             npr_oh;
  logic                        npr_any;

  src_e              win_src;
  logic [LINE_W-1:0] win_line;

  src_e              src_q, src_d;
  logic [LINE_W-1:0] line_q, line_d;
  logic [DEVS-1:0]   dev_q, dev_d;
  logic              load, clear, alive;

  for (genvar i = 0; i < NUM_BR; i++) begin : g_line
    assign line_req[i] = br_req_i[i*DEVS +: DEVS];
    first_one #(.W(DEVS)) u_pick (
      .req_i (line_req[i]),
      .oh_o  (line_oh[i]),
      .any_o (line_any[i])
    );
  end

  first_one #(.W(DEVS)) u_npr_pick (
    .req_i (npr_req_i),
    .oh_o  (npr_oh),
    .any_o (npr_any)
  );

  level_pick #(
    .NUM_BR  (NUM_BR),
    .BR_BASE (BR_BASE),
    .PRI_W   (PRI_W),
    .LINE_W  (LINE_W)
  ) u_level (
    .line_any_i  (line_any),
    .pir_level_i (pir_level_i),
    .cpu_pri_i   (cpu_pri_i),
    .win_src_o   (win_src),
    .win_line_o  (win_line)
  );

  // arbitration only while idle
  always_comb begin
    src_d  = SRC_NONE;
    line_d = '0;
    dev_d  = '0;
    load   = 1'b0;
    if (src_q == SRC_NONE) begin
      if (npr_any) begin
        src_d = SRC_NPR;
        dev_d = npr_oh;
        load  = 1'b1;
      end else if (instr_end_i && win_src != SRC_NONE) begin
        src_d  = win_src;
        line_d = win_line;
        dev_d  = (win_src == SRC_BR) ? line_oh[win_line] : '0;
        load   = 1'b1;
      end
    end
  end

  always_comb begin
    unique case (src_q)
      SRC_NPR:  alive = |(npr_req_i & dev_q);
      SRC_BR:   alive = |(line_req[line_q] & dev_q);
      SRC_PIR:  alive = (pir_level_i != '0);
      default:  alive = 1'b0;
    endcase
  end

  assign clear = (src_q != SRC_NONE) && !alive;

  grant_reg #(.DEVS(DEVS), .LINE_W(LINE_W)) u_gnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .clear_i  (clear),
    .src_d_i  (src_d),
    .line_d_i (line_d),
    .dev_d_i  (dev_d),
    .src_q_o  (src_q),
    .line_q_o (line_q),
    .dev_q_o  (dev_q)
  );

  for (genvar i = 0; i < NUM_BR; i++) begin : g_gnt
    assign br_gnt_o[i*DEVS +: DEVS] =
      (src_q == SRC_BR && line_q == LINE_W'(i)) ? dev_q : '0;
  end

  assign npr_gnt_o  = (src_q == SRC_NPR) ? dev_q : '0;
  assign pir_gnt_o  = (src_q == SRC_PIR);
  assign cpu_owns_o = (src_q == SRC_NONE);
endmodule

// File: rtl/bus_req_arbiter_chk.sv
module bus_req_arbiter_chk #(
  parameter int DEVS   = 4,
  parameter int NUM_BR = 4,
  parameter int PRI_W  = 3
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [PRI_W-1:0]       cpu_pri_i,
  input logic                   instr_end_i,
  input logic [DEVS-1:0]        npr_req_i,
  input logic [NUM_BR*DEVS-1:0] br_req_i,
  input logic [PRI_W-1:0]       pir_level_i,
  input logic [DEVS-1:0]        npr_gnt_o,
  input logic [NUM_BR*DEVS-1:0] br_gnt_o,
  input logic                   pir_gnt_o,
  input logic                   cpu_owns_o
);
  a_r11_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({npr_gnt_o, br_gnt_o, pir_gnt_o}));

  a_r11_owns: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_owns_o == ({npr_gnt_o, br_gnt_o, pir_gnt_o} == '0));

  a_r2_npr_any_time: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_owns_o && |npr_req_i) |=> |npr_gnt_o);

  a_r8_npr_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_owns_o && |npr_req_i) |=> (!pir_gnt_o && br_gnt_o == '0));

  a_r3_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(|br_gnt_o) || $rose(pir_gnt_o)) |-> $past(instr_end_i));

  a_r4_pir_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pir_gnt_o) |-> ($past(pir_level_i) > $past(cpu_pri_i)));

  a_r9_hold_br: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(br_gnt_o & br_req_i)) |=> $stable(br_gnt_o));

  a_r9_hold_npr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(npr_gnt_o & npr_req_i)) |=> $stable(npr_gnt_o));

  a_r10_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|br_gnt_o && !(|(br_gnt_o & br_req_i))) ||
     (|npr_gnt_o && !(|(npr_gnt_o & npr_req_i))) ||
     (pir_gnt_o && pir_level_i == '0)) |=> cpu_owns_o);
endmodule

bind bus_req_arbiter bus_req_arbiter_chk #(
  .DEVS(DEVS), .NUM_BR(NUM_BR), .PRI_W(PRI_W)
) u_chk (.*);

// File: tb/sim_bus_req_arbiter.sv
`timescale 1ns/1ps
module sim_bus_req_arbiter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cpu_pri = '0;
  logic        instr_end = 1'b0;
  logic [3:0]  npr_req = '0;
  logic [15:0] br_req = '0;
  logic [2:0]  pir_level = '0;
  logic [3:0]  npr_gnt;
  logic [15:0] br_gnt;
  logic        pir_gnt, cpu_owns;

  int total = 0, bad = 0;
  bit done = 0, chk_on = 0;
  string tag = "R1 reset";

  // model state: 0 none, 1 npr, 2 br, 3 pir
  int m_src = 0, m_line = 0, m_dev = 0;

  always #5 clk = ~clk;

  bus_req_arbiter u0 (
    .clk_i(clk), .rst_ni(rst_n), .cpu_pri_i(cpu_pri), .instr_end_i(instr_end),
    .npr_req_i(npr_req), .br_req_i(br_req), .pir_level_i(pir_level),
    .npr_gnt_o(npr_gnt), .br_gnt_o(br_gnt), .pir_gnt_o(pir_gnt), .cpu_owns_o(cpu_owns)
  );

  always @(posedge clk or negedge rst_n) begin
    int s, l, d;
    if (!rst_n) begin
      m_src <= 0; m_line <= 0; m_dev <= 0;
    end else if (m_src == 0) begin
      s = 0; l = 0; d = 0;
      if (npr_req != 0) begin
        s = 1;
        for (int k = 3; k >= 0; k--) if (npr_req[k]) d = k;
      end else if (instr_end) begin
        for (int lv = 7; lv >= 1 && s == 0; lv--) begin
          if (lv > cpu_pri) begin
            if (pir_level == lv) s = 3;
            else if (lv >= 4 && br_req[(lv-4)*4 +: 4] != 0) begin
              s = 2; l = lv - 4;
              for (int k = 3; k >= 0; k--) if (br_req[l*4+k]) d = k;
            end
          end
        end
      end
      m_src <= s; m_line <= l; m_dev <= d;
    end else begin
      if ((m_src == 1 && !npr_req[m_dev]) ||
          (m_src == 2 && !br_req[m_line*4+m_dev]) ||
          (m_src == 3 && pir_level == 0))
        m_src <= 0;
    end
  end

  always @(negedge clk) begin
    logic [3:0]  e_npr;
    logic [15:0] e_br;
    logic        e_pir, e_own;
    if (chk_on && !done) begin
      e_npr = (m_src == 1) ? 4'(1 << m_dev) : '0;
      e_br  = (m_src == 2) ? 16'(1 << (m_line*4 + m_dev)) : '0;
      e_pir = (m_src == 3);
      e_own = (m_src == 0);
      total++;
      if (npr_gnt !== e_npr || br_gnt !== e_br || pir_gnt !== e_pir || cpu_owns !== e_own) begin
        bad++;
        $display("FAIL %s: actual npr=%h br=%h pir=%b own=%b expected npr=%h br=%h pir=%b own=%b",
                 tag, npr_gnt, br_gnt, pir_gnt, cpu_owns, e_npr, e_br, e_pir, e_own);
      end
    end
  end

  task automatic cyc(int n = 1);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic strobe();
    instr_end = 1'b1; cyc(); instr_end = 1'b0;
  endtask

  initial begin
    chk_on = 1;
    cyc(3);
    rst_n = 1'b1;
    cyc(2);

    tag = "R2 npr at pri 7 without strobe";
    cpu_pri = 3'd7; npr_req = 4'b0110;
    cyc(3);
    tag = "R9 npr hold under other changes";
    br_req = 16'hF000; instr_end = 1'b1; cpu_pri = 3'd0; npr_req = 4'b0111;
    cyc(2); instr_end = 1'b0;
    tag = "R10 npr release then R6 next device";
    npr_req = 4'b0101; br_req = '0;
    cyc(4);
    npr_req = '0; cyc(3);

    tag = "R3 br waits for boundary";
    cpu_pri = 3'd3; br_req = 16'h0C00;
    cyc(4);
    strobe(); cyc(2);
    tag = "R10 br release";
    br_req = '0; cyc(3);

    tag = "R4 masked at or below priority";
    cpu_pri = 3'd5; br_req = 16'h0010; pir_level = 3'd4;
    strobe(); cyc(2);
    pir_level = 3'd5; strobe(); cyc(2);
    cpu_pri = 3'd7; br_req = 16'hF000; pir_level = 3'd7; strobe(); cyc(2);
    br_req = '0; pir_level = '0; cyc(2);

    tag = "R5 highest line wins";
    cpu_pri = 3'd0; br_req = 16'h9A01;
    strobe(); cyc(2);
    br_req = 16'h0A01; cyc(3);
    tag = "R6 nearest device on line 6";
    strobe(); cyc(2);
    br_req = '0; cyc(3);

    tag = "R7 software wins tie";
    br_req = 16'h0200; pir_level = 3'd6;
    strobe(); cyc(2);
    tag = "R9 software hold";
    br_req = 16'hF000; pir_level = 3'd2; cyc(2);
    tag = "R10 software release";
    pir_level = '0; br_req = 16'h0200; cyc(3);
    br_req = '0; cyc(2);
    tag = "R7 higher line beats software";
    br_req = 16'h0400; pir_level = 3'd5;
    strobe(); cyc(2);
    br_req = '0; cyc(2);
    tag = "R7 software above lines";
    br_req = 16'h0008; pir_level = 3'd5; strobe(); cyc(2);
    pir_level = '0; br_req = '0; cyc(3);

    tag = "R8 npr beats all";
    npr_req = 4'b1000; br_req = 16'hFFFF; pir_level = 3'd7;
    strobe(); cyc(2);
    npr_req = '0; br_req = '0; pir_level = '0; cyc(3);

    tag = "R1 reset mid grant";
    br_req = 16'h1000; strobe(); cyc(); rst_n = 1'b0; cyc(2);
    rst_n = 1'b1; br_req = '0; cyc(2);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule